// File: doc/BRIEF.md
# Multichannel Serial Word Assembler

This block gathers bit-serial streams from up to six synchronous receiver channels and turns each stream into 24-bit words. The words arrive in blocks. A block is a parameterised number of data words followed by one check word. The check word makes every bit column across the block even. The block keeps each block in a per-channel staging area until the check word has arrived and has been compared. It then moves the whole block into a release slot that the host can read.

A host-side port scans the channels in ascending order. It offers each released block to the host one word at a time, through a valid/accept handshake, together with the channel number and an error mark. The error mark is set on every word of a block whose column parity failed. Bad data is therefore passed on with the mark and is not discarded. A one-cycle completion pulse follows each scan in which at least one word was taken.

If a block completes while the channel's release slot is still occupied, the newest block is lost and a sticky overrun bit is set for that channel.

Top module: `serial_word_assembler`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, frame_done and every overrun bit read 0.
- R2: Each channel shifts in one bit on every cycle its bit_valid bit is high, most significant bit first. 24 such bits form one word. The channels assemble independently and may complete words in the same cycle.
- R3: The first BLK_WORDS words of a block are data and the next word is the check word. The check word is never presented to the host. No data word of a block is presented before its check word has arrived.
- R4: out_mark is 0 for every word of a block whose data words XOR the check word to zero. Otherwise out_mark is 1 for all BLK_WORDS words of that block.
- R5: While out_valid is high and accept is low, out_chan, out_data and out_mark hold their values. A word is consumed on a rising edge where out_valid and accept are both high.
- R6: Channels are served in ascending index, wrapping from the last channel to 0. An empty channel costs one cycle and is passed over. All words of a block are delivered in arrival order before the next channel is served.
- R7: A block that completes while its channel's release slot is full is discarded, and bit c of overrun is set and stays set until reset. The block already held in the slot is delivered unchanged.
- R8: frame_done is high for exactly one cycle, after the scan leaves the last channel, and only if at least one word was accepted during that scan.
- R9: A block that completes on the same edge on which the final word of the same channel's released block is accepted takes over the freed slot, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | NCH | Per-channel strobe: the bit on bit_in is valid |
| bit_in | input | NCH | Per-channel serial data bit |
| accept | input | 1 | Host takes the presented word |
| out_valid | output | 1 | A word is presented |
| out_chan | output | $clog2(NCH) | Channel of the presented word |
| out_data | output | WORD_W | Presented data word |
| out_mark | output | 1 | Set when the word's block failed column parity |
| frame_done | output | 1 | One-cycle pulse at the end of a scan that moved data |
| overrun | output | NCH | Sticky per-channel lost-block flags |

## Verification
Two events can fall on the same edge: the host accepting the last word of a channel's released block, and the final bit of that channel's next check word arriving. The bench provokes this by draining all but one word of a block. It then streams a second block with accept held low, and raises accept together with the last serial bit. The result is correct if overrun stays clear and the second block is then delivered whole and with the right mark. The bench also completes blocks on two channels in the same cycle, while a third channel holds the port. This checks that serving follows ascending index with wrap-around.

// File: rtl/serial_word_assembler.sv
module serial_word_assembler #(
  parameter int NCH       = 6,
  parameter int WORD_W    = 24,
  parameter int BLK_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         bit_valid,
  input  logic [NCH-1:0]         bit_in,
  input  logic                   accept,
  output logic                   out_valid,
  output logic [$clog2(NCH)-1:0] out_chan,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_mark,
  output logic                   frame_done,
  output logic [NCH-1:0]         overrun
);
  localparam int CW = $clog2(NCH);
  localparam int BW = $clog2(WORD_W);
  localparam int IW = $clog2(BLK_WORDS);
  localparam int KW = $clog2(BLK_WORDS + 1);

  logic [WORD_W-1:0] sh    [NCH];
  logic [BW-1:0]     bcnt  [NCH];
  logic [KW-1:0]     kidx  [NCH];
  logic [WORD_W-1:0] acc   [NCH];
  logic [WORD_W-1:0] stg   [NCH][BLK_WORDS];
  logic [WORD_W-1:0] rel   [NCH][BLK_WORDS];
  logic [NCH-1:0]    rel_full, rel_bad;
  logic [WORD_W-1:0] full_word [NCH];
  logic [NCH-1:0]    slot_free;

  logic [CW-1:0] ptr;
  logic [IW-1:0] widx;
  logic          moved;

  wire take      = out_valid && accept;
  wire take_last = take && (widx == IW'(BLK_WORDS - 1));
  wire advance   = !out_valid || take_last;

  assign out_valid = rel_full[ptr];
  assign out_chan  = ptr;
  assign out_data  = rel[ptr][widx];
  assign out_mark  = rel_bad[ptr];

  always_comb
    for (int c = 0; c < NCH; c++) begin
      full_word[c] = {sh[c][WORD_W-2:0], bit_in[c]};
      slot_free[c] = !rel_full[c] || (take_last && ptr == CW'(c));
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; widx <= '0; moved <= 1'b0; frame_done <= 1'b0;
      rel_full <= '0; rel_bad <= '0; overrun <= '0;
      for (int c = 0; c < NCH; c++) begin
        sh[c] <= '0; bcnt[c] <= '0; kidx[c] <= '0; acc[c] <= '0;
      end
    end else begin
      frame_done <= 1'b0;
      if (take_last) begin
        widx <= '0;
        rel_full[ptr] <= 1'b0;
      end else if (take) begin
        widx <= widx + 1'b1;
      end
      if (advance) begin
        if (ptr == CW'(NCH - 1)) begin
          ptr        <= '0;
          frame_done <= moved || take;
          moved      <= 1'b0;
        end else begin
          ptr   <= ptr + 1'b1;
          moved <= moved || take;
        end
      end else begin
        moved <= moved || take;
      end
      for (int c = 0; c < NCH; c++) begin
        if (bit_valid[c]) begin
          if (bcnt[c] == BW'(WORD_W - 1)) begin
            bcnt[c] <= '0;
            if (kidx[c] < KW'(BLK_WORDS)) begin
              stg[c][kidx[c][IW-1:0]] <= full_word[c];
              acc[c]  <= acc[c] ^ full_word[c];
              kidx[c] <= kidx[c] + 1'b1;
            end else begin
              kidx[c] <= '0;
              acc[c]  <= '0;
              if (slot_free[c]) begin
                for (int k = 0; k < BLK_WORDS; k++) rel[c][k] <= stg[c][k];
                rel_full[c] <= 1'b1;
                rel_bad[c]  <= |(acc[c] ^ full_word[c]);
              end else begin
                overrun[c] <= 1'b1;
              end
            end
          end else begin
            sh[c]   <= full_word[c];
            bcnt[c] <= bcnt[c] + 1'b1;
          end
        end
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !accept |=> out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_mark));

  assert_block_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_last |=> out_valid && $stable(out_chan));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(ptr) == CW'(NCH - 1));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: tb/serial_word_assembler_tb.sv
module serial_word_assembler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int W   = 24;
  localparam int NB  = 4;

  // {bad[31:28], channel[27:24], seed[23:0]}
  localparam logic [31:0] TAB [6] = '{
    32'h00123456, 32'h11ABCDEF, 32'h02FFFFFF,
    32'h13000000, 32'h04800001, 32'h15555555 };

  logic clk = 0, rst_n = 0, accept = 0;
  logic [NCH-1:0] bit_valid = '0, bit_in = '0;
  logic out_valid, out_mark, frame_done;
  logic [2:0] out_chan;
  logic [W-1:0] out_data;
  logic [NCH-1:0] overrun;
  int checks = 0, failures = 0, done_cnt = 0;

  serial_word_assembler #(.NCH(NCH), .WORD_W(W), .BLK_WORDS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .accept(accept), .out_valid(out_valid), .out_chan(out_chan),
    .out_data(out_data), .out_mark(out_mark), .frame_done(frame_done),
    .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (frame_done) done_cnt <= done_cnt + 1;

  function automatic logic [W-1:0] wv(input logic [W-1:0] seed, input int ch, input int k);
    return seed ^ W'(ch * 24'h100001) ^ W'(k * 24'h010203);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_blocks(input logic [NCH-1:0] mask, input logic [W-1:0] seed,
                             input logic [NCH-1:0] bad, input bit acc_last);
    logic [W-1:0] par [NCH];
    logic [W-1:0] cur [NCH];
    for (int c = 0; c < NCH; c++) par[c] = '0;
    for (int k = 0; k <= NB; k++) begin
      for (int c = 0; c < NCH; c++) begin
        if (k < NB) begin
          cur[c] = wv(seed, c, k);
          par[c] = par[c] ^ cur[c];
        end else begin
          cur[c] = par[c] ^ (bad[c] ? 24'h000001 : 24'h0);
        end
      end
      for (int b = W - 1; b >= 0; b--) begin
        @(negedge clk);
        bit_valid = mask;
        for (int c = 0; c < NCH; c++) bit_in[c] = cur[c][b];
        if (acc_last && k == NB && b == 0) accept = 1;
      end
    end
    @(negedge clk);
    bit_valid = '0;
    accept = 0;
  endtask

  task automatic take(input int ch, input logic [W-1:0] data, input logic mark, input string req);
    int n = 0;
    @(negedge clk);
    while (!out_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(out_valid && out_chan == 3'(ch) && out_data == data && out_mark == mark, req,
          {4'(out_valid), 3'(out_chan), out_mark, out_data}, {4'd1, 3'(ch), mark, data});
    accept = 1;
    @(negedge clk);
    accept = 0;
  endtask

  task automatic take_block(input int ch, input logic [W-1:0] seed, input logic mark, input string req);
    for (int k = 0; k < NB; k++) take(ch, wv(seed, ch, k), mark, req);
  endtask

  task automatic quiet(input int cyc, input string req);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    check(!seen, req, 32'(seen), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(!out_valid && !frame_done && overrun == '0, "R1 in reset",
          {out_valid, frame_done, 24'(overrun)}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && !frame_done && overrun == '0, "R1 after reset",
          {out_valid, frame_done, 24'(overrun)}, 0);

    // R2 R3 R4: one block per channel from the vector table
    for (int i = 0; i < 6; i++) begin
      int ch = int'(TAB[i][27:24]);
      send_blocks(NCH'(1) << ch, TAB[i][23:0], NCH'(TAB[i][28]) << ch, 0);
      take_block(ch, TAB[i][23:0], TAB[i][28], "R2/R4 table word");
      quiet(10, "R3 check word not presented");
    end

    // R6: ch3 parks the port, then ch0 and ch5 complete together
    base = done_cnt;
    send_blocks(6'b001000, 24'h3C3C3C, '0, 0);
    send_blocks(6'b100001, 24'h0F0F0F, 6'b000001, 0);
    take_block(3, 24'h3C3C3C, 1'b0, "R6 parked channel first");
    take_block(5, 24'h0F0F0F, 1'b0, "R6 ascending next");
    take_block(0, 24'h0F0F0F, 1'b1, "R6 wrap to channel 0 R4 mark");
    repeat (10) @(negedge clk);
    check(done_cnt > base, "R8 pulse after drain", 32'(done_cnt - base), 32'd1);

    // R9: last accept and new block completion on the same edge
    send_blocks(6'b000001, 24'h246801, '0, 0);
    for (int k = 0; k < NB - 1; k++) take(0, wv(24'h246801, 0, k), 1'b0, "R9 first block");
    @(negedge clk);
    check(out_valid && out_data == wv(24'h246801, 0, NB - 1), "R9 final word waiting",
          out_data, wv(24'h246801, 0, NB - 1));
    send_blocks(6'b000001, 24'h13579B, 6'b000001, 1);
    check(overrun == '0, "R9 no overrun", 32'(overrun), 32'd0);
    take_block(0, 24'h13579B, 1'b1, "R9 second block");

    // R7: overrun on channel 2
    send_blocks(6'b000100, 24'hA1A1A1, '0, 0);
    send_blocks(6'b000100, 24'hB2B2B2, '0, 0);
    check(overrun == 6'b000100, "R7 overrun set", 32'(overrun), 32'h4);
    take_block(2, 24'hA1A1A1, 1'b0, "R7 held block intact");
    quiet(30, "R7 dropped block absent");
    check(overrun == 6'b000100, "R7 overrun sticky", 32'(overrun), 32'h4);

    // R8: idle scans give no pulse
    base = done_cnt;
    repeat (30) @(negedge clk);
    check(done_cnt == base, "R8 no pulse when idle", 32'(done_cnt - base), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule